// File: doc/BRIEF.md
# Vector Strided Load/Store Sequencer

This block turns one vector memory instruction into a stream of single-element memory requests. It also computes the updated base address that the instruction writes back to its base register. The instruction arrives as a start pulse that carries:

- a base address;
- an optional auxiliary operand, used as an element limit, a stride, or both;
- an element size code;
- a set of mode flags;
- for stores, the full contents of the vector registers.

The sequencer then issues one element per accepted cycle on a valid/ready request port. For loads it collects the in-order read responses into a register image. That image is one vector register, or four consecutive registers in grouped mode. Elements past the limit are left at zero.

Decode, the register file, caches and exceptions are outside the block. When the flags form an illegal combination, the block raises an error flag together with completion. It issues no requests in that case and produces no writeback.

Top module: `vstride_seq`

## Requirements
- R1: The element size code `esz` is 0, 1 or 2, meaning 1, 2 or 4 bytes; code 3 is illegal. Elements per register are (VLEN_BITS/8) >> esz. `op_group4` makes the instruction cover four registers; otherwise it covers one.
- R2: With `op_clamp`, the element count is min(`aux_opnd`, total elements). Load image elements at or beyond the count read zero, and stores issue no request beyond the count.
- R3: With `op_stride`, each register's first address is the previous register's first address plus `aux_opnd` × element bytes. Without it, the next register starts directly after the last element transferred. Elements within a register are contiguous.
- R4: The quarter store (`op_quarter`) splits each register into four equal parts. Each part is written contiguously, and the address advances by `aux_opnd` × element bytes after every part.
- R5: The following combinations raise `err` together with `done`, issue no request and give no writeback:
  - length or stride without `op_has_aux`;
  - `op_has_aux` with none of clamp, stride or bump;
  - clamp with stride but without bump;
  - a quarter form that is a load, has clamp, or lacks stride;
  - size code 3.
- R6: A non-quarter strided store needs `aux_opnd` of at least one register's element count. A quarter store needs at least a quarter of it. A smaller value is illegal as in R5.
- R7: With `op_bump` and a non-zero count, `bump_en` is asserted and `bump_addr` equals the base plus an increment that depends on the variant:
  - clamp with stride: one register's bytes;
  - no auxiliary operand: register bytes × register count;
  - clamp only: count × element bytes;
  - stride only: `aux_opnd` × element bytes × register count, times 4 for the quarter store;
  - otherwise: `aux_opnd` × element bytes.
- R8: Data is little-endian within an element. Store data is taken from the register image at the element's position and zero-extended to 32 bits. A load element takes only its low element bytes from `mem_rsp_data`.
- R9: One element is transferred per accepted cycle. While `mem_req_valid` is high and `mem_req_ready` is low, the request holds its address, data and direction.
- R10: `done` is a single-cycle pulse. For stores it comes in the cycle after the last request is accepted; for loads it comes in the cycle after the last response. `bump_en` is only ever high together with `done`.
- R11: `start` is ignored while `busy` is high, and `busy` covers the `done` cycle. The store data image and all operands are sampled in the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one instruction (taken when not busy) |
| op_load | input | 1 | 1 = load, 0 = store |
| op_has_aux | input | 1 | Auxiliary operand present |
| op_clamp | input | 1 | Auxiliary operand limits the element count |
| op_stride | input | 1 | Auxiliary operand is the per-register stride |
| op_bump | input | 1 | Produce a base writeback |
| op_group4 | input | 1 | Cover four consecutive registers |
| op_quarter | input | 1 | Quarter-strided store form |
| esz | input | 2 | Element size code |
| base_addr | input | 32 | Byte base address |
| aux_opnd | input | 32 | Length and/or stride in elements |
| st_data | input | 4*VLEN_BITS | Store register image, register 0 in the low bits |
| busy | output | 1 | Instruction in flight or completing |
| mem_req_valid | output | 1 | Request valid |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_write | output | 1 | 1 = write |
| mem_req_addr | output | 32 | Element byte address |
| mem_req_size | output | 2 | Element size code |
| mem_req_wdata | output | 32 | Zero-extended write element |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data |
| ld_data | output | 4*VLEN_BITS | Load register image |
| done | output | 1 | Completion pulse |
| err | output | 1 | Illegal combination flag, with done |
| bump_en | output | 1 | Base writeback valid |
| bump_addr | output | 32 | Updated base address |

## Verification
The bench builds the sequencer with VLEN_BITS = 128. That gives 16, 8 or 4 elements per register, quarters of 4, 2 or 1 elements, and a four-register image of 64 bytes. At this size every variant can be listed element by element against an independent model.

With 4-byte elements a quarter holds a single element, so the quarter stride boundary falls at 1. The smallest legal store stride sits at 4, 8 or 16 elements, within easy reach of boundary tests. Element limits of 0, partial registers and values above the total can all be driven with small operands.

// File: rtl/vss_pkg.sv
// Shared types and helpers for the strided vector sequencer.
// Assumes 32-bit byte addresses and element size codes 0..2.
package vss_pkg;
    localparam int ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } seq_st_e;

    // Byte-lane mask covering one element of the given size code.
    function automatic logic [31:0] lane_mask(input logic [1:0] esz);
        case (esz)
            2'd0:    lane_mask = 32'h0000_00ff;
            2'd1:    lane_mask = 32'h0000_ffff;
            default: lane_mask = 32'hffff_ffff;
        endcase
    endfunction
endpackage

// File: rtl/vss_plan.sv
// Combinational instruction planner: checks legality and derives the element
// count, segment length and step, and the base writeback value.
// Assumes GROUP_REGS is a power of two and VLEN_BYTES >= 4.
module vss_plan
    import vss_pkg::*;
#(
    parameter int VLEN_BYTES = 32,
    parameter int GROUP_REGS = 4,
    parameter int CW         = 8
) (
    input  logic          op_load,
    input  logic          op_has_aux,
    input  logic          op_clamp,
    input  logic          op_stride,
    input  logic          op_bump,
    input  logic          op_group4,
    input  logic          op_quarter,
    input  logic [1:0]    esz,
    input  addr_t         base_addr,
    input  addr_t         aux_opnd,
    output logic          legal,
    output logic [CW-1:0] count,
    output logic [CW-1:0] seg_len,
    output addr_t         seg_step,
    output logic          bump_on,
    output addr_t         bump_value
);
    localparam int GRP_LOG = $clog2(GROUP_REGS);

    logic [CW-1:0] epr;
    logic [CW-1:0] total;
    logic [CW-1:0] qlen;
    logic [3:0]    grp_sh;
    addr_t         aux_b;
    addr_t         reg_b;
    addr_t         inc;
    logic          bad_flags;
    logic          bad_stride;

    // Element counts for one register, the group and one quarter.
    always_comb begin
        grp_sh = op_group4 ? 4'(GRP_LOG) : 4'd0;
        epr    = CW'(VLEN_BYTES) >> esz;
        total  = epr << grp_sh;
        qlen   = epr >> 2;
        count  = (op_clamp && (aux_opnd < addr_t'(total))) ? CW'(aux_opnd) : total;
        seg_len = op_quarter ? qlen : epr;
    end

    // Byte distances: auxiliary operand scaled, and one full register.
    always_comb begin
        aux_b    = aux_opnd << esz;
        reg_b    = addr_t'(VLEN_BYTES);
        seg_step = op_stride ? aux_b : reg_b;
    end

    // Flag-combination and minimum-stride legality.
    always_comb begin
        bad_flags = (esz == 2'd3)
                  || (!op_has_aux && (op_clamp || op_stride))
                  || (op_has_aux && !op_clamp && !op_stride && !op_bump)
                  || (op_clamp && op_stride && !op_bump)
                  || (op_quarter && (op_load || op_clamp || !op_stride || (qlen == '0)));
        bad_stride = (!op_load && op_stride && !op_quarter && (aux_opnd < addr_t'(epr)))
                  || (op_quarter && (aux_opnd < addr_t'(qlen)));
        legal = !bad_flags && !bad_stride;
    end

    // Variant-dependent base increment.
    always_comb begin
        if (op_clamp && op_stride) begin
            inc = reg_b;
        end else if (!op_has_aux) begin
            inc = reg_b << grp_sh;
        end else if (op_clamp) begin
            inc = addr_t'(count) << esz;
        end else if (op_stride) begin
            inc = aux_b << (grp_sh + (op_quarter ? 4'd2 : 4'd0));
        end else begin
            inc = aux_b;
        end
        bump_value = base_addr + inc;
        bump_on    = legal && op_bump && (count != '0);
    end
endmodule

// File: rtl/vss_addr_gen.sv
// Request generator: walks the element sequence segment by segment, one
// element per accepted cycle, and selects store data from the captured image.
// Assumes seg_len > 0 and count > 0 whenever init is pulsed.
module vss_addr_gen
    import vss_pkg::*;
#(
    parameter int TOT_BYTES = 128,
    parameter int CW        = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   init,
    input  addr_t                  start_addr,
    input  logic [TOT_BYTES*8-1:0] st_data,
    input  logic [1:0]             esz,
    input  logic [CW-1:0]          count,
    input  logic [CW-1:0]          seg_len,
    input  addr_t                  seg_step,
    input  logic                   is_load,
    input  logic                   req_ready,
    output logic                   req_valid,
    output logic                   req_write,
    output addr_t                  req_addr,
    output logic [1:0]             req_size,
    output logic [31:0]            req_wdata,
    output logic                   last_acc
);
    localparam int TOT_BITS = TOT_BYTES * 8;
    localparam int BOW      = CW + 2;
    localparam int BPW      = BOW + 3;

    logic                issuing;
    addr_t               eaddr;
    addr_t               base;
    logic [CW-1:0]       seg_pos;
    logic [CW-1:0]       flat;
    logic [TOT_BITS-1:0] st_q;
    logic                accept;
    logic                seg_end;
    addr_t               es_b;
    logic [BOW-1:0]      boff;
    logic [BPW-1:0]      bitpos;
    logic [TOT_BITS+31:0] pad;

    // Handshake and position decode.
    always_comb begin
        accept   = issuing && req_ready;
        last_acc = accept && (flat == count - CW'(1));
        seg_end  = (seg_pos == seg_len - CW'(1));
        es_b     = addr_t'(1) << esz;
    end

    // Walk state: element address, segment base, segment position, flat index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issuing <= 1'b0;
            eaddr   <= '0;
            base    <= '0;
            seg_pos <= '0;
            flat    <= '0;
        end else if (init) begin
            issuing <= 1'b1;
            eaddr   <= start_addr;
            base    <= start_addr;
            seg_pos <= '0;
            flat    <= '0;
        end else if (accept) begin
            flat <= flat + CW'(1);
            if (last_acc) begin
                issuing <= 1'b0;
            end else if (seg_end) begin
                seg_pos <= '0;
                base    <= base + seg_step;
                eaddr   <= base + seg_step;
            end else begin
                seg_pos <= seg_pos + CW'(1);
                eaddr   <= eaddr + es_b;
            end
        end
    end

    // Capture the store image at instruction start.
    always_ff @(posedge clk) begin
        if (init) begin
            st_q <= st_data;
        end
    end

    // Select and zero-extend the current store element.
    always_comb begin
        boff      = BOW'(flat) << esz;
        bitpos    = {boff, 3'b000};
        pad       = {32'b0, st_q};
        req_wdata = pad[bitpos +: 32] & lane_mask(esz);
    end

    assign req_valid = issuing;
    assign req_write = !is_load;
    assign req_addr  = eaddr;
    assign req_size  = esz;
endmodule

// File: rtl/vss_load_pack.sv
// Response collector: places in-order read responses into the register image.
// Elements never written stay at the zero set by clear.
module vss_load_pack #(
    parameter int TOT_BYTES = 128,
    parameter int CW        = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   rsp_valid,
    input  logic [31:0]            rsp_data,
    input  logic [1:0]             esz,
    input  logic [CW-1:0]          count,
    output logic [TOT_BYTES*8-1:0] ld_data,
    output logic                   rsp_last
);
    localparam int BOW = CW + 2;

    logic [TOT_BYTES*8-1:0] ld_q;
    logic [CW-1:0]          rsp_cnt;
    logic [BOW-1:0]         pos;

    // Byte position of the next returning element.
    always_comb begin
        pos      = BOW'(rsp_cnt) << esz;
        rsp_last = rsp_valid && (rsp_cnt == count - CW'(1));
    end

    // Clear the image at start, then write each response's element bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ld_q    <= '0;
            rsp_cnt <= '0;
        end else if (rsp_valid) begin
            for (int b = 0; b < 4; b++) begin
                if ((b < (1 << esz)) && ((int'(pos) + b) < TOT_BYTES)) begin
                    ld_q[(int'(pos) + b) * 8 +: 8] <= rsp_data[b * 8 +: 8];
                end
            end
            rsp_cnt <= rsp_cnt + CW'(1);
        end
    end

    assign ld_data = ld_q;
endmodule

// File: rtl/vstride_seq.sv
// Top of the strided vector load/store sequencer. Accepts one instruction per
// start pulse, runs it to completion, then pulses done with error and
// writeback status. Assumes in-order read responses, one per read request.
module vstride_seq
    import vss_pkg::*;
#(
    parameter int VLEN_BITS  = 256,
    parameter int GROUP_REGS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic                            op_load,
    input  logic                            op_has_aux,
    input  logic                            op_clamp,
    input  logic                            op_stride,
    input  logic                            op_bump,
    input  logic                            op_group4,
    input  logic                            op_quarter,
    input  logic [1:0]                      esz,
    input  logic [31:0]                     base_addr,
    input  logic [31:0]                     aux_opnd,
    input  logic [GROUP_REGS*VLEN_BITS-1:0] st_data,
    output logic                            busy,
    output logic                            mem_req_valid,
    input  logic                            mem_req_ready,
    output logic                            mem_req_write,
    output logic [31:0]                     mem_req_addr,
    output logic [1:0]                      mem_req_size,
    output logic [31:0]                     mem_req_wdata,
    input  logic                            mem_rsp_valid,
    input  logic [31:0]                     mem_rsp_data,
    output logic [GROUP_REGS*VLEN_BITS-1:0] ld_data,
    output logic                            done,
    output logic                            err,
    output logic                            bump_en,
    output logic [31:0]                     bump_addr
);
    localparam int VLEN_BYTES = VLEN_BITS / 8;
    localparam int TOT_BYTES  = VLEN_BYTES * GROUP_REGS;
    localparam int CW         = $clog2(TOT_BYTES + 1);

    seq_st_e       state;
    logic          done_q;
    logic          err_q;
    logic          bump_en_q;
    addr_t         bump_q;
    logic          c_load;
    logic [1:0]    c_esz;
    logic [CW-1:0] c_count;
    logic [CW-1:0] c_seg_len;
    addr_t         c_seg_step;
    logic          c_bump_on;

    logic          p_legal;
    logic [CW-1:0] p_count;
    logic [CW-1:0] p_seg_len;
    addr_t         p_seg_step;
    logic          p_bump_on;
    addr_t         p_bump_value;

    logic          take;
    logic          gen_init;
    logic          pack_clear;
    logic          last_acc;
    logic          rsp_last;

    vss_plan #(
        .VLEN_BYTES (VLEN_BYTES),
        .GROUP_REGS (GROUP_REGS),
        .CW         (CW)
    ) plan_i (
        .op_load    (op_load),
        .op_has_aux (op_has_aux),
        .op_clamp   (op_clamp),
        .op_stride  (op_stride),
        .op_bump    (op_bump),
        .op_group4  (op_group4),
        .op_quarter (op_quarter),
        .esz        (esz),
        .base_addr  (base_addr),
        .aux_opnd   (aux_opnd),
        .legal      (p_legal),
        .count      (p_count),
        .seg_len    (p_seg_len),
        .seg_step   (p_seg_step),
        .bump_on    (p_bump_on),
        .bump_value (p_bump_value)
    );

    // Start acceptance and the pulses it produces for the sub-blocks.
    always_comb begin
        take       = (state == ST_IDLE) && !done_q && start;
        gen_init   = take && p_legal && (p_count != '0);
        pack_clear = take && p_legal && op_load;
    end

    vss_addr_gen #(
        .TOT_BYTES (TOT_BYTES),
        .CW        (CW)
    ) gen_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (gen_init),
        .start_addr (base_addr),
        .st_data    (st_data),
        .esz        (c_esz),
        .count      (c_count),
        .seg_len    (c_seg_len),
        .seg_step   (c_seg_step),
        .is_load    (c_load),
        .req_ready  (mem_req_ready),
        .req_valid  (mem_req_valid),
        .req_write  (mem_req_write),
        .req_addr   (mem_req_addr),
        .req_size   (mem_req_size),
        .req_wdata  (mem_req_wdata),
        .last_acc   (last_acc)
    );

    vss_load_pack #(
        .TOT_BYTES (TOT_BYTES),
        .CW        (CW)
    ) pack_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (pack_clear),
        .rsp_valid (mem_rsp_valid),
        .rsp_data  (mem_rsp_data),
        .esz       (c_esz),
        .count     (c_count),
        .ld_data   (ld_data),
        .rsp_last  (rsp_last)
    );

    // Sequencing state, latched instruction plan and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            bump_en_q  <= 1'b0;
            bump_q     <= '0;
            c_load     <= 1'b0;
            c_esz      <= '0;
            c_count    <= '0;
            c_seg_len  <= '0;
            c_seg_step <= '0;
            c_bump_on  <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            bump_en_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        c_load     <= op_load;
                        c_esz      <= esz;
                        c_count    <= p_count;
                        c_seg_len  <= p_seg_len;
                        c_seg_step <= p_seg_step;
                        c_bump_on  <= p_bump_on;
                        bump_q     <= p_bump_value;
                        if (!p_legal) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else if (p_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (last_acc) begin
                        if (c_load) begin
                            state <= ST_DRAIN;
                        end else begin
                            state     <= ST_IDLE;
                            done_q    <= 1'b1;
                            bump_en_q <= c_bump_on;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (rsp_last) begin
                        state     <= ST_IDLE;
                        done_q    <= 1'b1;
                        bump_en_q <= c_bump_on;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE) || done_q;
    assign done      = done_q;
    assign err       = err_q;
    assign bump_en   = bump_en_q;
    assign bump_addr = bump_q;
endmodule

// File: rtl/vss_chk.sv
// Protocol checker for the sequencer ports, bound to every instance of the top.
module vss_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_write,
    input logic [31:0] mem_req_addr,
    input logic [31:0] mem_req_wdata,
    input logic        mem_rsp_valid,
    input logic        done,
    input logic        err,
    input logic        bump_en
);
    // R9: a stalled request keeps its contents.
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)
             && $stable(mem_req_write)));

    // R11: requests only appear while the block reports busy.
    a_r11_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    // R10: completion is a single-cycle pulse.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: writeback valid only together with completion.
    a_r10_bump_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        bump_en |-> done);

    // R5: an error completes without writeback.
    a_r5_err_no_bump: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !bump_en));

    // R10: read responses only arrive during an instruction.
    a_r10_rsp_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> busy);
endmodule

bind vstride_seq vss_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .err           (err),
    .bump_en       (bump_en)
);

// File: tb/vstride_seq_tb_top.sv
// Directed bench for the strided sequencer, built with 128-bit registers.
module vstride_seq_tb_top;
    localparam int VB    = 16;
    localparam int GR    = 4;
    localparam int TBYT  = VB * GR;
    localparam int TBITS = TBYT * 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             op_load = 1'b0, op_has_aux = 1'b0, op_clamp = 1'b0, op_stride = 1'b0;
    logic             op_bump = 1'b0, op_group4 = 1'b0, op_quarter = 1'b0;
    logic [1:0]       esz = 2'd0;
    logic [31:0]      base_addr = '0, aux_opnd = '0;
    logic [TBITS-1:0] st_vec = '0;
    logic             busy, mem_req_valid, mem_req_write, done, err, bump_en;
    logic             mem_req_ready = 1'b1;
    logic [31:0]      mem_req_addr, mem_req_wdata, bump_addr;
    logic [1:0]       mem_req_size;
    logic             mem_rsp_valid = 1'b0;
    logic [31:0]      mem_rsp_data = '0;
    logic [TBITS-1:0] ld_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit stall_en = 1'b1;

    int          n_exp, n_got, mism, last_lat;
    logic [31:0] exp_addr [0:TBYT-1];
    logic [31:0] exp_data [0:TBYT-1];
    logic [TBITS-1:0] exp_ld;
    bit          exp_bump_en, cur_ld;
    logic [31:0] exp_bump;
    logic [31:0] rspq [$];

    vstride_seq #(.VLEN_BITS(VB * 8), .GROUP_REGS(GR)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_load(op_load),
        .op_has_aux(op_has_aux), .op_clamp(op_clamp), .op_stride(op_stride),
        .op_bump(op_bump), .op_group4(op_group4), .op_quarter(op_quarter),
        .esz(esz), .base_addr(base_addr), .aux_opnd(aux_opnd), .st_data(st_vec),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .ld_data(ld_data), .done(done), .err(err), .bump_en(bump_en),
        .bump_addr(bump_addr)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Memory model: responses, ready pattern, request recording and comparison.
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rspq.size() > 0) begin
                mem_rsp_data  = rspq.pop_front();
                mem_rsp_valid = 1'b1;
            end
            mem_req_ready = !stall_en || ((cyc % 3) != 2);
            #1;
            if (mem_req_valid && mem_req_ready) begin
                if (n_got >= n_exp) mism++;
                else if (mem_req_addr != exp_addr[n_got] || mem_req_write == cur_ld
                         || (!cur_ld && mem_req_wdata != exp_data[n_got])) mism++;
                n_got++;
                if (!mem_req_write) begin
                    rspq.push_back({mem_req_addr[7:0] + 8'd3, mem_req_addr[7:0] + 8'd2,
                                    mem_req_addr[7:0] + 8'd1, mem_req_addr[7:0]});
                end
            end
        end
    end

    // Reference model: appends one element to the expected stream.
    task automatic add_elem(input logic [31:0] a, input int e, input int es);
        logic [31:0] d;
        d = '0;
        for (int b = 0; b < es; b++) begin
            d[b*8 +: 8] = st_vec[(e*es + b)*8 +: 8];
            if (cur_ld) exp_ld[(e*es + b)*8 +: 8] = 8'(a + 32'(b));
        end
        exp_addr[n_exp] = a;
        exp_data[n_exp] = d;
        n_exp++;
    endtask

    // Reference model of the element stream and writeback per the requirements.
    task automatic build_exp(input bit ld, input bit has_aux, input bit cl, input bit sd,
                             input bit bp, input bit g4, input bit qt, input int sz,
                             input logic [31:0] base, input int aux, input bit experr);
        int es, epr, nr, tot, cnt, left, n, qs;
        logic [31:0] a, inc;
        cur_ld = ld; n_exp = 0; exp_ld = '0; exp_bump_en = 1'b0; exp_bump = '0;
        if (experr) return;
        es = 1 << sz; epr = VB / es; nr = g4 ? 4 : 1; tot = epr * nr;
        cnt = cl ? ((aux < tot) ? aux : tot) : tot;
        a = base; left = cnt; qs = epr / 4;
        for (int r = 0; r < nr; r++) begin
            if (qt) begin
                for (int q = 0; q < 4; q++) begin
                    for (int j = 0; j < qs; j++) add_elem(a + 32'(j*es), r*epr + q*qs + j, es);
                    a = a + 32'(aux*es);
                end
            end else begin
                n = (left < epr) ? left : epr;
                for (int i = 0; i < n; i++) add_elem(a + 32'(i*es), r*epr + i, es);
                left = left - n;
                a = a + 32'(sd ? aux*es : n*es);
            end
        end
        if (bp && cnt > 0) begin
            exp_bump_en = 1'b1;
            if (cl && sd)      inc = 32'(VB);
            else if (!has_aux) inc = 32'(VB * nr);
            else if (cl)       inc = 32'(cnt * es);
            else if (sd)       inc = 32'(aux * es * nr * (qt ? 4 : 1));
            else               inc = 32'(aux * es);
            exp_bump = base + inc;
        end
    endtask

    // Runs one instruction and checks stream, error, writeback and load image.
    task automatic run_op(input string tag, input bit ld, input bit has_aux, input bit cl,
                          input bit sd, input bit bp, input bit g4, input bit qt,
                          input int sz, input logic [31:0] base, input int aux,
                          input bit experr, input bit poke);
        int bad;
        while (busy) @(negedge clk);
        for (int i = 0; i < TBYT; i++) st_vec[i*8 +: 8] = 8'(i*29 + aux + sz*7 + 5);
        build_exp(ld, has_aux, cl, sd, bp, g4, qt, sz, base, aux, experr);
        @(negedge clk);
        n_got = 0; mism = 0;
        op_load = ld; op_has_aux = has_aux; op_clamp = cl; op_stride = sd; op_bump = bp;
        op_group4 = g4; op_quarter = qt; esz = 2'(sz); base_addr = base; aux_opnd = 32'(aux);
        start = 1'b1;
        last_lat = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (poke && last_lat == 2) begin
                start = 1'b1; op_load = ~ld; op_has_aux = 1'b0; op_clamp = 1'b0;
                op_stride = 1'b0; op_bump = 1'b1; base_addr = 32'h9000; esz = 2'd0;
            end
            #1;
            last_lat++;
            if (done || last_lat > 2000) break;
        end
        chk(done, tag, "completion", longint'(done), 1);
        chk(err == experr, tag, "error flag", longint'(err), longint'(experr));
        chk(n_got == n_exp && mism == 0, tag, "element stream (count)", n_got, n_exp);
        chk(bump_en == exp_bump_en, tag, "writeback enable", longint'(bump_en),
            longint'(exp_bump_en));
        if (exp_bump_en)
            chk(bump_addr == exp_bump, tag, "writeback value", bump_addr, exp_bump);
        if (ld && !experr) begin
            bad = 0;
            for (int i = 0; i < TBYT; i++) if (ld_data[i*8 +: 8] != exp_ld[i*8 +: 8]) bad++;
            chk(bad == 0, tag, "load image bytes wrong", bad, 0);
        end
    endtask

    task automatic t_reset();
        chk(!busy, "R10", "busy after reset", longint'(busy), 0);
        chk(!done, "R10", "done after reset", longint'(done), 0);
        chk(!mem_req_valid, "R9", "request after reset", longint'(mem_req_valid), 0);
        chk(!err && !bump_en, "R5", "err/bump after reset", longint'(err), 0);
    endtask

    task automatic t_plain_loads();
        run_op("R1/R8 single load", 1, 0, 0, 0, 0, 0, 0, 0, 32'h100, 0, 0, 0);
        run_op("R1/R7 grouped load bump", 1, 0, 0, 0, 1, 1, 0, 1, 32'h200, 0, 0, 0);
        run_op("R7 post-only load", 1, 1, 0, 0, 1, 0, 0, 0, 32'h300, 7, 0, 0);
    endtask

    task automatic t_clamp();
        run_op("R2/R7 clamp partial", 1, 1, 1, 0, 1, 1, 0, 2, 32'h400, 5, 0, 0);
        run_op("R2/R7 clamp zero", 1, 1, 1, 0, 1, 1, 0, 0, 32'h480, 0, 0, 0);
        run_op("R2 clamp over total", 1, 1, 1, 0, 0, 0, 0, 0, 32'h500, 200, 0, 0);
        run_op("R2 store clamp", 0, 1, 1, 0, 0, 0, 0, 0, 32'h580, 9, 0, 0);
    endtask

    task automatic t_stride();
        run_op("R3/R7 stride load", 1, 1, 0, 1, 1, 1, 0, 0, 32'h600, 20, 0, 0);
        run_op("R3/R7 clamp+stride load", 1, 1, 1, 1, 1, 1, 0, 1, 32'h700, 10, 0, 0);
        run_op("R3/R8 stride store", 0, 1, 0, 1, 1, 1, 0, 2, 32'h800, 6, 0, 0);
        run_op("R6 stride store at minimum", 0, 1, 0, 1, 0, 0, 0, 2, 32'h880, 4, 0, 0);
    endtask

    task automatic t_quarter();
        run_op("R4/R7 quarter grouped", 0, 1, 0, 1, 1, 1, 1, 1, 32'h900, 3, 0, 0);
        run_op("R4 quarter single min", 0, 1, 0, 1, 0, 0, 1, 0, 32'ha00, 4, 0, 0);
    endtask

    task automatic t_illegal();
        run_op("R6 stride store too small", 0, 1, 0, 1, 1, 0, 0, 2, 32'hb00, 3, 1, 0);
        run_op("R6 quarter too small", 0, 1, 0, 1, 1, 0, 1, 1, 32'hb00, 1, 1, 0);
        run_op("R5 clamp without aux", 1, 0, 1, 0, 1, 0, 0, 0, 32'hb00, 0, 1, 0);
        run_op("R5 aux with nothing", 1, 1, 0, 0, 0, 0, 0, 0, 32'hb00, 4, 1, 0);
        run_op("R5 clamp+stride no bump", 1, 1, 1, 1, 0, 0, 0, 0, 32'hb00, 4, 1, 0);
        run_op("R5 quarter load", 1, 1, 0, 1, 1, 0, 1, 0, 32'hb00, 8, 1, 0);
        run_op("R5 size code 3", 1, 0, 0, 0, 1, 0, 0, 3, 32'hb00, 0, 1, 0);
    endtask

    task automatic t_busy_start();
        run_op("R11 start while busy", 0, 0, 0, 0, 1, 0, 0, 0, 32'hc00, 0, 0, 1);
    endtask

    task automatic t_latency();
        stall_en = 1'b0;
        run_op("R9/R10 unstalled store", 0, 0, 0, 0, 0, 0, 0, 2, 32'hd00, 0, 0, 0);
        chk(last_lat == 5, "R9/R10", "cycles to done for 4 elements", last_lat, 5);
        stall_en = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        wait (cyc > 150000);
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_plain_loads();
        t_clamp();
        t_stride();
        t_quarter();
        t_illegal();
        t_busy_start();
        t_latency();
        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule